// File: doc/BRIEF.md
# Field-Clocked Zone Delay Line

This block is a cycle-level model of a signal wire that runs across a chain of clock zones in a cellular logic fabric driven by a three-phase field clock. A base clock drives a three-step ring that produces three phase pulses, each one base cycle wide and one third of a period after the one before. Zones along the wire take the phases in a repeating order, so zone k belongs to phase k mod 3. In any base cycle every zone is in exactly one of three states. In reset its contents are erased and it shows a neutral marker. In switch it takes a new value from the zone before it. In hold it keeps that value stable for the zone after it.

A bit therefore advances one zone per base cycle, and a wire of N zones delays it by one full phase period for every three zones crossed. The number of active zones is chosen at run time, up to a build-time maximum, by tapping the chain. The tapped value is re-timed onto the phase-1 boundary, so the output moves by whole phase periods. Per-zone state flags and the phase pulses are brought out for observation.

Top module: `czl_zone_line`

## Requirements
- R1: `phase_clk` is one-hot. It is 3'b001 in reset and rotates one position per base clock edge (bit 0, then bit 1, then bit 2, then bit 0). Bit j is the pulse of phase j+1.
- R2: Zone k (index from 0 at the input end) belongs to phase k mod 3. Its `zone_switch` flag is high exactly when `phase_clk[k mod 3]` is high.
- R3: Each zone shows exactly one of `zone_reset`, `zone_switch` and `zone_hold`. A zone is in hold in the cycle after its switch cycle and in reset in the cycle after its hold cycle.
- R4: Whenever zone k is in hold, zone k+1 is in switch and zone k-1 is in reset.
- R5: A zone holds valid data only while in hold. A reset zone shows a neutral marker, and no zone takes up valid data from a predecessor that did not hold valid data.
- R6: `din` is sampled only at base clock edges where `phase_clk[0]` is high. Its value at every other edge has no effect.
- R7: With D = ceil(Neff/3), the value of `dout` after the m-th phase-1 edge since reset equals `din` as sampled at the (m-D)-th phase-1 edge. `dout` changes only at phase-1 edges.
- R8: `dout_vld` is low from reset until the first phase-1 edge that delivers a sampled bit (m = D), and stays high after that.
- R9: The effective zone count Neff is `zone_cnt`, except that 0 counts as 1 and values above MAX_ZONES count as MAX_ZONES.
- R10: While `rst_n` is low, `dout` and `dout_vld` are 0 and `phase_clk` is 3'b001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Bit entering zone 0 |
| zone_cnt | input | $clog2(MAX_ZONES+1) | Number of zones the wire crosses |
| dout | output | 1 | Delayed bit, re-timed to the phase-1 boundary |
| dout_vld | output | 1 | High once a sampled bit has reached the output |
| phase_clk | output | 3 | One-hot phase pulses |
| zone_reset | output | MAX_ZONES | Per-zone reset-state flag |
| zone_switch | output | MAX_ZONES | Per-zone switch-state flag |
| zone_hold | output | MAX_ZONES | Per-zone hold-state flag |

## Verification
Two events can land on the same edge. One is the tapped last zone ending its hold step, when the capture register takes its value. The other is the phase-1 edge that re-times the output. They coincide only when Neff is a multiple of three, and then the output must take the bypass path instead of the capture register. The bench runs zone counts in every residue class mod 3 (1 to 7, 15, 16 and both clamped values) with random data. It uses phase-1 slots whose values are the opposite of the garbage driven in the other slots, and compares every output cycle against a history of sampled bits shifted by ceil(Neff/3). An off-by-one-period error on either path shows up as a mismatch in that residue class only.

// File: rtl/czl_pkg.sv
package czl_pkg;

   localparam int NUM_PHASES = 3;

   typedef enum logic [1:0] {
      ZS_RESET  = 2'd0,
      ZS_SWITCH = 2'd1,
      ZS_HOLD   = 2'd2
   } zone_state_e;

   function automatic int phase_of(input int zone_idx);
      return zone_idx % NUM_PHASES;
   endfunction

endpackage

// File: rtl/czl_phase_ring.sv
module czl_phase_ring
   import czl_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   output logic [NUM_PHASES-1:0] ring_o
);

   localparam logic [NUM_PHASES-1:0] RING_INIT = NUM_PHASES'(1);

   logic [NUM_PHASES-1:0] ring_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_q <= RING_INIT;
      end else begin
         ring_q <= {ring_q[NUM_PHASES-2:0], ring_q[NUM_PHASES-1]};
      end
   end

   assign ring_o = ring_q;

endmodule

// File: rtl/czl_zone_cell.sv
module czl_zone_cell
   import czl_pkg::*;
#(
   parameter int PHASE = 0
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PHASES-1:0] ring_i,
   input  logic                  pred_val_i,
   input  logic                  pred_vld_i,
   output logic                  val_o,
   output logic                  vld_o,
   output zone_state_e           state_o
);

   localparam int SW_BIT   = PHASE % NUM_PHASES;
   localparam int HOLD_BIT = (PHASE + 1) % NUM_PHASES;

   logic val_q;
   logic vld_q;

   // switch step ends with a load; hold step ends with an erase
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= 1'b0;
         vld_q <= 1'b0;
      end else if (ring_i[SW_BIT]) begin
         val_q <= pred_val_i;
         vld_q <= pred_vld_i;
      end else if (ring_i[HOLD_BIT]) begin
         val_q <= 1'b0;
         vld_q <= 1'b0;
      end
   end

   always_comb begin
      if (ring_i[SW_BIT]) begin
         state_o = ZS_SWITCH;
      end else if (ring_i[HOLD_BIT]) begin
         state_o = ZS_HOLD;
      end else begin
         state_o = ZS_RESET;
      end
   end

   assign val_o = val_q;
   assign vld_o = vld_q;

endmodule

// File: rtl/czl_tap_select.sv
module czl_tap_select #(
   parameter int MAX_ZONES = 16,
   parameter int CNT_W     = 5
)(
   input  logic [CNT_W-1:0]     zone_cnt_i,
   input  logic [MAX_ZONES-1:0] zone_val_i,
   input  logic [MAX_ZONES-1:0] zone_vld_i,
   output logic                 tap_val_o,
   output logic                 tap_vld_o
);

   localparam int IDX_W = (MAX_ZONES > 1) ? $clog2(MAX_ZONES) : 1;

   generate
      if (MAX_ZONES == 1) begin : g_single
         logic unused_cnt;
         assign unused_cnt = ^zone_cnt_i;
         assign tap_val_o  = zone_val_i[0];
         assign tap_vld_o  = zone_vld_i[0];
      end else begin : g_mux
         logic [CNT_W-1:0] cnt_eff;
         logic [IDX_W-1:0] tap_idx;

         always_comb begin
            if (zone_cnt_i == '0) begin
               cnt_eff = CNT_W'(1);
            end else if (zone_cnt_i > CNT_W'(MAX_ZONES)) begin
               cnt_eff = CNT_W'(MAX_ZONES);
            end else begin
               cnt_eff = zone_cnt_i;
            end
         end

         assign tap_idx = IDX_W'(cnt_eff - CNT_W'(1));

         always_comb begin
            tap_val_o = 1'b0;
            tap_vld_o = 1'b0;
            for (int i = 0; i < MAX_ZONES; i++) begin
               if (tap_idx == IDX_W'(i)) begin
                  tap_val_o = zone_val_i[i];
                  tap_vld_o = zone_vld_i[i];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/czl_out_retime.sv
module czl_out_retime (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic tap_val_i,
   input  logic tap_vld_i,
   output logic dout_o,
   output logic dout_vld_o
);

   logic cap_val_q;
   logic cap_vld_q;
   logic dout_q;
   logic dout_vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_val_q  <= 1'b0;
         cap_vld_q  <= 1'b0;
         dout_q     <= 1'b0;
         dout_vld_q <= 1'b0;
      end else begin
         if (tap_vld_i) begin
            cap_val_q <= tap_val_i;
            cap_vld_q <= 1'b1;
         end
         if (load_i) begin
            // bypass when the tap ends its hold on this very edge
            dout_q     <= tap_vld_i ? tap_val_i : cap_val_q;
            dout_vld_q <= tap_vld_i | cap_vld_q;
         end
      end
   end

   assign dout_o     = dout_q;
   assign dout_vld_o = dout_vld_q;

endmodule

// File: rtl/czl_zone_line.sv
module czl_zone_line
   import czl_pkg::*;
#(
   parameter  int MAX_ZONES = 16,
   localparam int CNT_W     = $clog2(MAX_ZONES + 1)
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  din,
   input  logic [CNT_W-1:0]      zone_cnt,
   output logic                  dout,
   output logic                  dout_vld,
   output logic [2:0]            phase_clk,
   output logic [MAX_ZONES-1:0]  zone_reset,
   output logic [MAX_ZONES-1:0]  zone_switch,
   output logic [MAX_ZONES-1:0]  zone_hold
);

   generate
      if (MAX_ZONES < 1) begin : g_bad_zones
         $error("czl_zone_line: MAX_ZONES must be at least 1");
      end
      if (NUM_PHASES != 3) begin : g_bad_phases
         $error("czl_zone_line: phase ring must have three steps");
      end
   endgenerate

   logic [NUM_PHASES-1:0] ring;
   logic [MAX_ZONES-1:0]  zone_val;
   logic [MAX_ZONES-1:0]  zone_vld;
   zone_state_e           zone_st [MAX_ZONES];
   logic                  tap_val;
   logic                  tap_vld;

   czl_phase_ring ring_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ring_o (ring)
   );

   generate
      for (genvar k = 0; k < MAX_ZONES; k++) begin : g_zone
         logic pred_val;
         logic pred_vld;
         if (k == 0) begin : g_head
            assign pred_val = din;
            assign pred_vld = 1'b1;
         end else begin : g_body
            assign pred_val = zone_val[k-1];
            assign pred_vld = zone_vld[k-1];
         end

         czl_zone_cell #(
            .PHASE (phase_of(k))
         ) cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ring_i     (ring),
            .pred_val_i (pred_val),
            .pred_vld_i (pred_vld),
            .val_o      (zone_val[k]),
            .vld_o      (zone_vld[k]),
            .state_o    (zone_st[k])
         );

         assign zone_reset[k]  = (zone_st[k] == ZS_RESET);
         assign zone_switch[k] = (zone_st[k] == ZS_SWITCH);
         assign zone_hold[k]   = (zone_st[k] == ZS_HOLD);
      end
   endgenerate

   czl_tap_select #(
      .MAX_ZONES (MAX_ZONES),
      .CNT_W     (CNT_W)
   ) tap_i (
      .zone_cnt_i (zone_cnt),
      .zone_val_i (zone_val),
      .zone_vld_i (zone_vld),
      .tap_val_o  (tap_val),
      .tap_vld_o  (tap_vld)
   );

   czl_out_retime retime_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ring[0]),
      .tap_val_i  (tap_val),
      .tap_vld_i  (tap_vld),
      .dout_o     (dout),
      .dout_vld_o (dout_vld)
   );

   assign phase_clk = ring;

endmodule

// File: rtl/czl_zone_line_chk.sv
module czl_zone_line_chk #(
   parameter int MAX_ZONES = 16
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic [2:0]           phase_clk,
   input logic [MAX_ZONES-1:0] zone_reset,
   input logic [MAX_ZONES-1:0] zone_switch,
   input logic [MAX_ZONES-1:0] zone_hold,
   input logic [MAX_ZONES-1:0] zone_vld,
   input logic                 dout,
   input logic                 dout_vld
);

   AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(phase_clk)); // R1

   AST_RING_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (phase_clk == {$past(phase_clk[1:0]), $past(phase_clk[2])})); // R1

   AST_RESET_VALUES: assert property (@(posedge clk)
      !rst_n |=> (!rst_n |-> (dout == 1'b0 && dout_vld == 1'b0 && phase_clk == 3'b001))); // R10

   AST_OUT_ONLY_P1: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_clk[0] |=> ($stable(dout) && $stable(dout_vld))); // R7

   AST_VLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |=> dout_vld); // R8

   generate
      for (genvar k = 0; k < MAX_ZONES; k++) begin : g_zchk
         AST_ZONE_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({zone_reset[k], zone_switch[k], zone_hold[k]}) == 1); // R3

         AST_ZONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
            zone_switch[k] == phase_clk[k % 3]); // R2

         AST_SWITCH_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            zone_switch[k] |=> zone_hold[k]); // R3

         AST_HOLD_THEN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            zone_hold[k] |=> zone_reset[k]); // R3

         AST_VALID_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            zone_vld[k] |-> zone_hold[k]); // R5

         if (k > 0) begin : g_pred
            AST_NO_NEUTRAL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(zone_vld[k]) |-> $past(zone_vld[k-1])); // R5
         end

         if (k > 0 && k < MAX_ZONES - 1) begin : g_nb
            AST_NEIGHBOUR_STATES: assert property (@(posedge clk) disable iff (!rst_n)
               zone_hold[k] |-> (zone_switch[k+1] && zone_reset[k-1])); // R4
         end
      end
   endgenerate

endmodule

bind czl_zone_line czl_zone_line_chk #(
   .MAX_ZONES (MAX_ZONES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .phase_clk   (phase_clk),
   .zone_reset  (zone_reset),
   .zone_switch (zone_switch),
   .zone_hold   (zone_hold),
   .zone_vld    (zone_vld),
   .dout        (dout),
   .dout_vld    (dout_vld)
);

// File: tb/czl_zone_line_tb_top.sv
`timescale 1ns/1ps
module czl_zone_line_tb_top;

   localparam int MAXZ = 16;
   localparam int CW   = $clog2(MAXZ + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            din = 1'b0;
   logic [CW-1:0]   zone_cnt = '0;
   logic            dout;
   logic            dout_vld;
   logic [2:0]      phase_clk;
   logic [MAXZ-1:0] zone_reset;
   logic [MAXZ-1:0] zone_switch;
   logic [MAXZ-1:0] zone_hold;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit hist [0:255];

   always #10 clk = ~clk;

   czl_zone_line #(.MAX_ZONES(MAXZ)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .din         (din),
      .zone_cnt    (zone_cnt),
      .dout        (dout),
      .dout_vld    (dout_vld),
      .phase_clk   (phase_clk),
      .zone_reset  (zone_reset),
      .zone_switch (zone_switch),
      .zone_hold   (zone_hold)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R9: 0 counts as 1, above MAXZ counts as MAXZ
   function automatic int eff_cnt(input int cnt);
      if (cnt == 0) return 1;
      if (cnt > MAXZ) return MAXZ;
      return cnt;
   endfunction

   function automatic int exp_delay(input int cnt);
      return (eff_cnt(cnt) + 2) / 3;
   endfunction

   // mode 0: random; 1: sampled slots 1, other slots 0; 2: the reverse
   task automatic run_cfg(input int cnt, input int nedges, input int mode);
      int d;
      bit exp_do;
      bit exp_vld;
      logic [MAXZ-1:0] exp_sw;
      logic [MAXZ-1:0] exp_hd;
      logic [MAXZ-1:0] exp_rs;
      d = exp_delay(cnt);
      rst_n    = 1'b0;
      zone_cnt = CW'(cnt);
      din      = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(dout == 1'b0 && dout_vld == 1'b0 && phase_clk == 3'b001, "R10",
            "reset state", {dout, dout_vld, phase_clk}, 5'b00001);
      rst_n = 1'b1;
      for (int e = 0; e < nedges; e++) begin
         if (e % 3 == 0) begin
            bit b;
            b = (mode == 0) ? bit'($urandom() & 1) : (mode == 1);
            hist[e / 3] = b;
            din = b;
         end else begin
            din = (mode == 0) ? 1'($urandom() & 1) : (mode == 2);  // R6 garbage slot
         end
         check(phase_clk == 3'(1 << (e % 3)), "R1", "phase pulse",
               phase_clk, 3'(1 << (e % 3)));
         for (int k = 0; k < MAXZ; k++) begin
            exp_sw[k] = (k % 3 == e % 3);
            exp_hd[k] = ((k + 1) % 3 == e % 3);
            exp_rs[k] = ((k + 2) % 3 == e % 3);
         end
         // R2 R3 R4 zone state flags
         check(zone_switch == exp_sw, "R2", "switch flags", zone_switch, exp_sw);
         check(zone_hold == exp_hd && zone_reset == exp_rs, "R4", "hold/reset flags",
               {zone_hold, zone_reset}, {exp_hd, exp_rs});
         @(posedge clk);
         @(negedge clk);
         begin
            int m;
            m = e / 3;
            exp_vld = (m >= d);
            exp_do  = exp_vld ? hist[m - d] : 1'b0;
         end
         check(dout == exp_do, "R7", $sformatf("dout n=%0d edge=%0d", cnt, e),
               dout, exp_do);
         check(dout_vld == exp_vld, "R8 R5", $sformatf("dout_vld n=%0d edge=%0d", cnt, e),
               dout_vld, exp_vld);
      end
   endtask

   initial begin
      void'($urandom(32'h0000C2A5));
      run_cfg(1, 60, 0);
      run_cfg(2, 60, 0);
      run_cfg(3, 60, 0);
      run_cfg(4, 60, 0);
      run_cfg(5, 60, 0);
      run_cfg(6, 60, 0);
      run_cfg(7, 60, 0);
      run_cfg(15, 90, 0);
      run_cfg(16, 90, 0);
      run_cfg(0, 45, 0);   // R9 low clamp
      run_cfg(31, 90, 0);  // R9 high clamp
      run_cfg(16, 60, 1);  // R6 sampled slots opposite to garbage
      run_cfg(7, 60, 2);   // R6 reverse polarity
      run_cfg(3, 45, 1);   // R6
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(100000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule